// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of samples by a fixed number of clock cycles. It is meant for long delays, where a chain of flip-flops would cost too much area. Each sample is written once into a dual-port RAM and is not moved after that. A write pointer and a read pointer step through the RAM together, and the read pointer is always one entry ahead of the write pointer. Each cycle the block writes the new sample and reads the sample that was written exactly `DEPTH` cycles earlier.

The read port is registered. Together with the one-entry pointer offset, this gives the same timing at the ports as a `DEPTH`-stage register chain. For the first `DEPTH` cycles after reset the output holds no real data yet. The block therefore drives a valid flag that rises once the line has filled. An elaboration parameter selects one of two pointer schemes: two separate address counters, or one counter with the write address derived from it. The two schemes behave the same at the ports.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_i` is high at a rising edge, the read address is loaded with 0 and the write address with all ones. After that edge, `valid_o` is 0 and `dout_o` is 0.
- R2: After each rising edge with `rst_i` low, both addresses are one higher than before, modulo `DEPTH`. The address after `DEPTH-1` is 0. Data stays correct over many wraps of the pointers.
- R3: The write address always equals the read address minus one, modulo `DEPTH`, so the two addresses never match. The first valid output is the first sample taken after reset.
- R4: Number the rising edges after reset release t = 0, 1, 2, and so on. After edge t, `dout_o` equals the `din_i` sampled at edge t-`DEPTH`+1. This is the output of a `DEPTH`-stage register chain.
- R5: `valid_o` is 0 after edges 0 to `DEPTH`-2 and becomes 1 after edge `DEPTH`-1. It stays 1 until the next reset.
- R6: A reset in the middle of a stream clears `valid_o`. Once the line is valid again, no sample taken before that reset ever appears on `dout_o`.
- R7: With `SHARED_PTR`=1 the write address is derived from the read counter. The port behaviour is identical to the two-counter variant.
- R8: `DEPTH` must be a power of two and at least 2, and `DATA_W` must be at least 1. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | DATA_W | Sample written this cycle |
| dout_o | output | DATA_W | Sample written `DEPTH` cycles earlier |
| valid_o | output | 1 | High once the line has filled since reset |

## Verification
The bench samples the first valid output of each fill. An offset error between the pointers would show there as a neighbouring sample, and a badly timed fill flag would rise one cycle early or late. Long random, ramp and constant streams wrap the pointers many times, which exposes a bad wrap or an address collision as corrupted or repeated data. A reset in the middle of a stream checks that the flag drops, so stale RAM contents are never presented as valid. Instances with `DEPTH`=2 and with the shared-pointer variant run beside the default.

// File: rtl/dl_pkg.sv
package dl_pkg;

   // True when n is a power of two of at least 2
   function automatic bit depth_ok(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/dl_addr_ctr.sv
// Free-running address counter with a synchronous reset value.
module dl_addr_ctr #(
   parameter int AW = 4,
   parameter logic [AW-1:0] RST_VAL = '0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   output logic [AW-1:0] addr_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) addr_o <= RST_VAL;
      else       addr_o <= addr_o + AW'(1);
   end

endmodule

// File: rtl/dl_sdp_ram.sv
// Simple dual-port RAM: one write port and one registered read port.
module dl_sdp_ram #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) store[waddr_i] <= wdata_i;
   end

   // Only the output register is reset; the array keeps its contents
   always_ff @(posedge clk_i) begin
      if (rst_i) rdata_o <= '0;
      else       rdata_o <= store[raddr_i];
   end

endmodule

// File: rtl/dl_fill_mon.sv
// Raises the valid flag after the read pointer first reaches the top entry.
module dl_fill_mon #(
   parameter int AW = 4
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic          valid_o
);

   logic at_top;
   assign at_top = (rd_addr_i == {AW{1'b1}});

   always_ff @(posedge clk_i) begin
      if (rst_i) valid_o <= 1'b0;
      else       valid_o <= valid_o | at_top;
   end

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
   parameter int DATA_W     = 16,
   parameter int DEPTH      = 256,
   parameter bit SHARED_PTR = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              valid_o
);

   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] RD_RST = '0;
   localparam logic [AW-1:0] WR_RST = {AW{1'b1}};

   // R8: elaboration-time parameter checks
   if (!dl_pkg::depth_ok(DEPTH)) begin : g_bad_depth
      $error("ram_delay_line: DEPTH must be a power of two >= 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ram_delay_line: DATA_W must be at least 1");
   end

   logic [AW-1:0] rd_addr;
   logic [AW-1:0] wr_addr;

   dl_addr_ctr #(.AW(AW), .RST_VAL(RD_RST)) u_rd_ctr (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .addr_o (rd_addr)
   );

   if (SHARED_PTR) begin : g_shared_ptr
      // R7: one counter; the write address trails by one entry
      assign wr_addr = rd_addr - AW'(1);
   end else begin : g_two_ctr
      dl_addr_ctr #(.AW(AW), .RST_VAL(WR_RST)) u_wr_ctr (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .addr_o (wr_addr)
      );
   end

   dl_sdp_ram #(.DW(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .we_i    (1'b1),
      .waddr_i (wr_addr),
      .wdata_i (din_i),
      .raddr_i (rd_addr),
      .rdata_o (dout_o)
   );

   dl_fill_mon #(.AW(AW)) u_fill (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .rd_addr_i (rd_addr),
      .valid_o   (valid_o)
   );

endmodule

// File: rtl/ram_delay_line_chk.sv
module ram_delay_line_chk #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic [AW-1:0] rd_addr,
   input logic [AW-1:0] wr_addr,
   input logic          valid_o
);

   localparam logic [AW-1:0] TOP = {AW{1'b1}};

   logic          rst_q;
   logic          armed_q;
   logic [AW-1:0] rd_prev;

   always_ff @(posedge clk_i) begin
      rst_q   <= rst_i;
      armed_q <= !rst_i;
      rd_prev <= rd_addr;
   end

   // R1
   rst_val_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rst_q |-> (rd_addr == '0 && wr_addr == TOP && !valid_o));

   // R2
   ptr_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      armed_q |-> (rd_addr == rd_prev + AW'(1)));

   // R3
   ptr_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_addr == rd_addr - AW'(1));

   // R3
   no_collide_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_addr != wr_addr);

   // R5
   fill_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!valid_o && rd_addr == TOP) |=> valid_o);

   // R5
   fill_early_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!valid_o && rd_addr != TOP) |=> !valid_o);

   // R5
   fill_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |=> valid_o);

endmodule

bind ram_delay_line ram_delay_line_chk #(.DEPTH(DEPTH)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .rd_addr (rd_addr),
   .wr_addr (wr_addr),
   .valid_o (valid_o)
);

// File: tb/ram_delay_line_tb.sv
`timescale 1ns/1ps
module ram_delay_line_tb;

   localparam int DW = 8;
   localparam int DA = 16;
   localparam int DB = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout_a, dout_s, dout_m;
   logic          vld_a, vld_s, vld_m;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   bit   after_mid = 1'b0;
   logic [DW-1:0] hist [$];

   always #2.5 clk = ~clk;

   ram_delay_line #(.DATA_W(DW), .DEPTH(DA), .SHARED_PTR(1'b0)) u_dut (
      .clk_i(clk), .rst_i(rst), .din_i(din), .dout_o(dout_a), .valid_o(vld_a));
   ram_delay_line #(.DATA_W(DW), .DEPTH(DA), .SHARED_PTR(1'b1)) u_dut_shr (
      .clk_i(clk), .rst_i(rst), .din_i(din), .dout_o(dout_s), .valid_o(vld_s));
   ram_delay_line #(.DATA_W(DW), .DEPTH(DB), .SHARED_PTR(1'b0)) u_dut_min (
      .clk_i(clk), .rst_i(rst), .din_i(din), .dout_o(dout_m), .valid_o(vld_m));

   // Reference: history of every sample taken since the last reset
   always @(posedge clk) begin
      if (rst) hist.delete();
      else     hist.push_back(din);
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_inst(input string name, input int d, input bit shr,
                             input logic v, input logic [DW-1:0] q);
      int    n;
      bit    ev;
      string tag;
      n = hist.size();
      if (rst) begin
         chk("R1", {name, " valid in reset"}, 32'(v), 32'd0);
         chk("R1", {name, " dout in reset"},  32'(q), 32'd0);
      end else begin
         ev = (n >= d);
         chk("R5", {name, " valid"}, 32'(v), 32'(ev));
         if (ev) begin
            if (shr)                        tag = "R7";
            else if (after_mid && n <= 2*d) tag = "R6";
            else if (n == d)                tag = "R3";
            else if (n > 2*d)               tag = "R2";
            else                            tag = "R4";
            chk(tag, {name, " dout"}, 32'(q), 32'(hist[n-d]));
         end
      end
   endtask

   task automatic step(input logic r, input logic [DW-1:0] d);
      @(negedge clk);
      check_inst("main",   DA, 1'b0, vld_a, dout_a);
      check_inst("shared", DA, 1'b1, vld_s, dout_s);
      check_inst("min",    DB, 1'b0, vld_m, dout_m);
      rst = r;
      din = d;
   endtask

   initial begin
      for (int i = 0; i < 4; i++)   step(1'b1, '0);            // R1 reset state
      for (int i = 0; i < 200; i++) step(1'b0, DW'($urandom)); // R4 random stream
      for (int i = 0; i < 60; i++)  step(1'b0, DW'(i));        // R2 ramp over wraps
      for (int i = 0; i < 40; i++)  step(1'b0, 8'hA5);         // constant run
      for (int i = 0; i < 3; i++)   step(1'b1, 8'hFF);         // R6 mid-stream reset
      after_mid = 1'b1;
      for (int i = 0; i < 150; i++)
         step(1'b0, (i % 3 == 0) ? DW'($urandom) : ((i % 2 == 0) ? 8'h55 : 8'hAA));
      for (int i = 0; i < 20; i++)  step(1'b0, DW'($urandom));
      step(1'b0, '0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         n_fail++;
         $display("FAIL R4 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule